// File: doc/BRIEF.md
# Host Port Resume Signaling Controller

This block runs the suspend and resume sequence of one downstream port of a host controller. Software places an idle, powered port into suspend. The port can leave suspend in two ways. Software can write 1 to the resume control bit, or the attached device can signal remote wakeup, which the block sees as a J-to-K change on the sampled line. In either case the block drives a K state on the port. It times that K itself, follows it with a short SE0 end-of-packet, and then returns the port to the idle speed that was in use before suspend.

The resume bit reads 1 for the whole resume and falls by itself once the port is idle. A write of 0 from software does nothing. A port change status bit records a resume that the device started; software clears it by writing 1. Loss of port power ends any sequence at once. When a resume finishes and run/stop is still low, frames cannot start in time and a high-speed device would fall back to full speed, so the block raises an error flag. A microsecond tick paces both timers.

Top module: `hrc_port_resume`

## Requirements
- R1: After reset the resume bit, port change bit, K drive, SE0 drive and error flag are 0, and the port view is full-speed idle (port_view encoding: 2'b00 full-speed idle, 2'b01 high-speed idle, 2'b10 suspended, 2'b11 resuming).
- R2: A suspend_req pulse while the port is idle and powered moves the port view to suspended on the next cycle.
- R3: A write of 1 to the resume bit while suspended gives, on the next cycle, resume bit 1, drive_k 1 and view resuming, and it does not set the port change bit.
- R4: While suspended, a J-to-K change on line_state (encoding 2'b01 J, 2'b10 K, 2'b00 SE0) sets the resume bit and the port change bit on the next cycle. If a software write of 1 falls in the same cycle, the port change bit is still set.
- R5: drive_k stays high for exactly RESUME_US microsecond ticks, and drive_se0 then stays high for exactly EOP_US ticks, with the resume bit held at 1 throughout.
- R6: When the end-of-packet period is over, the resume bit reads 0 and the view returns to the idle speed captured while the port was last idle (port_hs), even if port_hs has changed since then.
- R7: A write of 0 to the resume bit has no effect. A suspended port stays suspended, and a running resume neither ends early nor lasts a different number of ticks.
- R8: When port_power is 0, the resume bit, drive_k and drive_se0 read 0 in the same cycle. The view becomes full-speed idle on the next cycle, and suspend_req is ignored.
- R9: late_sof_err is set when a resume completes while run_stop is 0. A resume that completes while run_stop is 1 clears it, and so does an accepted suspend_req.
- R10: The port change bit is cleared by a pcd_clr pulse. A wakeup in the same cycle as pcd_clr wins, and the bit stays 1.
- R11: A K that follows SE0 rather than J does not wake a suspended port. A J-to-K change while the port is idle sets nothing.
- R12: A write of 1 to the resume bit while the port is idle has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| us_tick | input | 1 | One-cycle pulse each microsecond |
| port_power | input | 1 | Port power enabled |
| run_stop | input | 1 | Controller run/stop state |
| port_hs | input | 1 | 1 when the link runs at high speed |
| line_state | input | 2 | Sampled line: 00 SE0, 01 J, 10 K |
| suspend_req | input | 1 | Pulse: place idle port into suspend |
| fpr_wr | input | 1 | Write strobe for the resume bit |
| fpr_wdata | input | 1 | Value written to the resume bit |
| pcd_clr | input | 1 | Write-1-to-clear strobe for port change |
| resume_bit | output | 1 | Resume control bit read value |
| port_change | output | 1 | Port change detect status |
| drive_k | output | 1 | Drive K state on the port |
| drive_se0 | output | 1 | Drive SE0 end-of-packet |
| port_view | output | 2 | Port state as encoded in R1 |
| late_sof_err | output | 1 | Resume ended before run/stop was set |

## Verification
Two events can collide in one cycle: a remote wakeup detected on the line, and a software write of 1 to the resume bit. The bench provokes this by presenting K on the line in the same cycle as the write, then checks that the port change bit is set just as it would be for a wakeup alone. A second collision is a wakeup in the same cycle as a clear of the port change bit. Here the bench expects the bit to read 1 on the following cycle and to clear only on a later, separate clear pulse.

// File: rtl/hrc_pkg.sv
package hrc_pkg;

    typedef enum logic [1:0] {
        PV_FS_IDLE   = 2'b00,
        PV_HS_IDLE   = 2'b01,
        PV_SUSPENDED = 2'b10,
        PV_RESUMING  = 2'b11
    } port_view_e;

    typedef enum logic [1:0] {
        FSM_IDLE,
        FSM_SUSP,
        FSM_DRIVE_K,
        FSM_EOP
    } fsm_e;

    localparam logic [1:0] LINE_J = 2'b01;
    localparam logic [1:0] LINE_K = 2'b10;

    typedef struct packed {
        logic       resume;
        logic       drive_k;
        logic       drive_se0;
        port_view_e view;
    } port_drive_t;

    function automatic int timer_width(input int a, input int b);
        int m;
        m = (a > b) ? a : b;
        return $clog2(m + 1);
    endfunction

    function automatic logic is_timed(input fsm_e s);
        return (s == FSM_DRIVE_K) || (s == FSM_EOP);
    endfunction

endpackage

// File: rtl/hrc_line_watch.sv
module hrc_line_watch
    import hrc_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic [1:0] line_i,
    output logic       wake_o
);
    logic [1:0] prev_q;

    always_ff @(posedge clk) begin
        if (rst) prev_q <= 2'b00;
        else     prev_q <= line_i;
    end

    assign wake_o = (prev_q == LINE_J) && (line_i == LINE_K);
endmodule

// File: rtl/hrc_tick_timer.sv
module hrc_tick_timer #(
    parameter int CW = 8
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          clr_i,
    input  logic          tick_i,
    input  logic [CW-1:0] limit_i,
    output logic          done_o
);
    logic [CW-1:0] cnt_q;
    logic          last;

    assign last   = (cnt_q == limit_i - CW'(1));
    assign done_o = !clr_i && tick_i && last;

    always_ff @(posedge clk) begin
        if (rst || clr_i)  cnt_q <= '0;
        else if (done_o)   cnt_q <= '0;
        else if (tick_i)   cnt_q <= cnt_q + CW'(1);
    end

    // the running count never passes the limit of the phase it times
    assert_cnt_in_range_R5: assert property (@(posedge clk) disable iff (rst)
        !clr_i |-> (cnt_q < limit_i));
endmodule

// File: rtl/hrc_port_fsm.sv
module hrc_port_fsm
    import hrc_pkg::*;
#(
    parameter int RESUME_US = 20000,
    parameter int EOP_US    = 2,
    parameter int CW        = 15
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          power_i,
    input  logic          run_stop_i,
    input  logic          hs_i,
    input  logic          suspend_req_i,
    input  logic          fpr_wr_i,
    input  logic          fpr_wdata_i,
    input  logic          pcd_clr_i,
    input  logic          wake_i,
    input  logic          done_i,
    output logic          tmr_clr_o,
    output logic [CW-1:0] limit_o,
    output port_drive_t   drv_o,
    output logic          pcd_o,
    output logic          late_err_o
);
    fsm_e st_q, st_d;
    logic hs_q;
    logic sw_resume;
    logic remote_wake;
    logic finish;

    assign sw_resume   = fpr_wr_i && fpr_wdata_i;
    assign remote_wake = power_i && (st_q == FSM_SUSP) && wake_i;
    assign finish      = power_i && (st_q == FSM_EOP) && done_i;

    always_comb begin
        st_d = st_q;
        if (!power_i) begin
            st_d = FSM_IDLE;
        end else begin
            case (st_q)
                FSM_IDLE:    if (suspend_req_i)           st_d = FSM_SUSP;
                FSM_SUSP:    if (wake_i || sw_resume)     st_d = FSM_DRIVE_K;
                FSM_DRIVE_K: if (done_i)                  st_d = FSM_EOP;
                FSM_EOP:     if (done_i)                  st_d = FSM_IDLE;
                default:                                  st_d = FSM_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= FSM_IDLE;
        else     st_q <= st_d;
    end

    // idle speed tracks the link while idle and freezes across suspend
    always_ff @(posedge clk) begin
        if (rst || !power_i)       hs_q <= 1'b0;
        else if (st_q == FSM_IDLE) hs_q <= hs_i;
    end

    always_ff @(posedge clk) begin
        if (rst)              pcd_o <= 1'b0;
        else if (remote_wake) pcd_o <= 1'b1;
        else if (pcd_clr_i)   pcd_o <= 1'b0;
    end

    always_ff @(posedge clk) begin
        if (rst)
            late_err_o <= 1'b0;
        else if (finish)
            late_err_o <= !run_stop_i;
        else if (power_i && (st_q == FSM_IDLE) && suspend_req_i)
            late_err_o <= 1'b0;
    end

    assign tmr_clr_o = !power_i || !is_timed(st_q);
    assign limit_o   = (st_q == FSM_EOP) ? CW'(EOP_US) : CW'(RESUME_US);

    always_comb begin
        drv_o.resume    = power_i && is_timed(st_q);
        drv_o.drive_k   = power_i && (st_q == FSM_DRIVE_K);
        drv_o.drive_se0 = power_i && (st_q == FSM_EOP);
        case (st_q)
            FSM_IDLE: drv_o.view = hs_q ? PV_HS_IDLE : PV_FS_IDLE;
            FSM_SUSP: drv_o.view = PV_SUSPENDED;
            default:  drv_o.view = PV_RESUMING;
        endcase
    end

    assert_remote_wake_R4: assert property (@(posedge clk) disable iff (rst)
        remote_wake |=> (pcd_o && drv_o.resume));

    assert_sw_no_change_R3: assert property (@(posedge clk) disable iff (rst)
        (power_i && st_q == FSM_SUSP && sw_resume && !wake_i && !pcd_o)
        |=> !pcd_o);

    assert_zero_write_R7: assert property (@(posedge clk) disable iff (rst)
        (power_i && st_q == FSM_SUSP && fpr_wr_i && !fpr_wdata_i && !wake_i)
        |=> (st_q == FSM_SUSP));

    assert_power_drop_R8: assert property (@(posedge clk) disable iff (rst)
        !power_i |=> (drv_o.view == PV_FS_IDLE));

    assert_late_flag_R9: assert property (@(posedge clk) disable iff (rst)
        (finish && !run_stop_i) |=> late_err_o);
endmodule

// File: rtl/hrc_port_resume.sv
module hrc_port_resume
    import hrc_pkg::*;
#(
    parameter int RESUME_US = 20000,
    parameter int EOP_US    = 2
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       us_tick,
    input  logic       port_power,
    input  logic       run_stop,
    input  logic       port_hs,
    input  logic [1:0] line_state,
    input  logic       suspend_req,
    input  logic       fpr_wr,
    input  logic       fpr_wdata,
    input  logic       pcd_clr,
    output logic       resume_bit,
    output logic       port_change,
    output logic       drive_k,
    output logic       drive_se0,
    output logic [1:0] port_view,
    output logic       late_sof_err
);
    localparam int CW = timer_width(RESUME_US, EOP_US);

    logic          wake;
    logic          tmr_clr;
    logic          tmr_done;
    logic [CW-1:0] tmr_limit;
    port_drive_t   drv;

    hrc_line_watch u_line (
        .clk    (clk),
        .rst    (rst),
        .line_i (line_state),
        .wake_o (wake)
    );

    hrc_tick_timer #(.CW(CW)) u_timer (
        .clk     (clk),
        .rst     (rst),
        .clr_i   (tmr_clr),
        .tick_i  (us_tick),
        .limit_i (tmr_limit),
        .done_o  (tmr_done)
    );

    hrc_port_fsm #(
        .RESUME_US (RESUME_US),
        .EOP_US    (EOP_US),
        .CW        (CW)
    ) u_fsm (
        .clk           (clk),
        .rst           (rst),
        .power_i       (port_power),
        .run_stop_i    (run_stop),
        .hs_i          (port_hs),
        .suspend_req_i (suspend_req),
        .fpr_wr_i      (fpr_wr),
        .fpr_wdata_i   (fpr_wdata),
        .pcd_clr_i     (pcd_clr),
        .wake_i        (wake),
        .done_i        (tmr_done),
        .tmr_clr_o     (tmr_clr),
        .limit_o       (tmr_limit),
        .drv_o         (drv),
        .pcd_o         (port_change),
        .late_err_o    (late_sof_err)
    );

    assign resume_bit = drv.resume;
    assign drive_k    = drv.drive_k;
    assign drive_se0  = drv.drive_se0;
    assign port_view  = drv.view;

    // K and SE0 are never driven together
    assert_single_drive_R5: assert property (@(posedge clk) disable iff (rst)
        !(drive_k && drive_se0));
endmodule

// File: tb/tb_hrc_port_resume.sv
`timescale 1ns/1ps
module tb_hrc_port_resume;
    localparam int RES_US = 10;
    localparam int EOP_US = 2;

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #5 clk = ~clk;

    logic       us_tick;
    logic       port_power, run_stop, port_hs;
    logic [1:0] line_state;
    logic       suspend_req, fpr_wr, fpr_wdata, pcd_clr;
    logic       resume_bit, port_change, drive_k, drive_se0, late_sof_err;
    logic [1:0] port_view;

    hrc_port_resume #(.RESUME_US(RES_US), .EOP_US(EOP_US)) dut (
        .clk(clk), .rst(rst), .us_tick(us_tick), .port_power(port_power),
        .run_stop(run_stop), .port_hs(port_hs), .line_state(line_state),
        .suspend_req(suspend_req), .fpr_wr(fpr_wr), .fpr_wdata(fpr_wdata),
        .pcd_clr(pcd_clr), .resume_bit(resume_bit), .port_change(port_change),
        .drive_k(drive_k), .drive_se0(drive_se0), .port_view(port_view),
        .late_sof_err(late_sof_err)
    );

    // tick every third cycle
    logic [1:0] tdiv;
    always @(posedge clk) begin
        if (rst) begin
            tdiv    <= 2'd0;
            us_tick <= 1'b0;
        end else begin
            tdiv    <= (tdiv == 2'd2) ? 2'd0 : tdiv + 2'd1;
            us_tick <= (tdiv == 2'd2);
        end
    end

    int k_ticks = 0;
    int e_ticks = 0;
    always @(negedge clk) begin
        if (us_tick && drive_k)   k_ticks++;
        if (us_tick && drive_se0) e_ticks++;
    end

    int nchk = 0;
    int nfail = 0;

    task automatic chk(input string tag, input int act, input int exp);
        nchk++;
        if (act != exp) begin
            nfail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic wait_end();
        for (int i = 0; i < 2000; i++) begin
            if (!resume_bit) break;
            @(negedge clk);
        end
    endtask

    task automatic do_suspend(input logic hs);
        @(negedge clk);
        port_hs = hs; line_state = 2'b01; suspend_req = 1'b1;
        @(negedge clk);
        suspend_req = 1'b0;
    endtask

    // fields: [4] hs  [3] flip speed during suspend  [2:1] wake mode (0 sw, 1 line, 2 both)  [0] run_stop
    localparam logic [4:0] VEC [6] = '{
        5'b1_0_00_1, 5'b0_0_01_1, 5'b1_1_01_0,
        5'b0_0_10_0, 5'b1_0_00_0, 5'b0_1_00_1
    };

    initial begin
        #2_000_000;
        nfail++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
        $finish;
    end

    initial begin
        int k0, e0;
        port_power = 1'b1; run_stop = 1'b1; port_hs = 1'b0; line_state = 2'b01;
        suspend_req = 1'b0; fpr_wr = 1'b0; fpr_wdata = 1'b0; pcd_clr = 1'b0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk("R1 resume", resume_bit, 0);
        chk("R1 change", port_change, 0);
        chk("R1 drive_k", drive_k, 0);
        chk("R1 drive_se0", drive_se0, 0);
        chk("R1 view", port_view, 0);
        chk("R1 err", late_sof_err, 0);

        foreach (VEC[v]) begin
            logic hs, flip, rs;
            logic [1:0] mode;
            {hs, flip, mode, rs} = VEC[v];
            run_stop = rs;
            do_suspend(hs);
            chk("R2 suspended", port_view, 2);
            chk("R9 cleared by suspend", late_sof_err, 0);
            if (flip) port_hs = ~hs;
            k0 = k_ticks; e0 = e_ticks;
            if (mode != 2'd1) begin fpr_wr = 1'b1; fpr_wdata = 1'b1; end
            if (mode != 2'd0) line_state = 2'b10;
            @(negedge clk);
            fpr_wr = 1'b0;
            chk("R3 resume bit", resume_bit, 1);
            chk("R3 drive_k", drive_k, 1);
            chk("R3 view", port_view, 3);
            chk("R4 change", port_change, (mode != 2'd0) ? 1 : 0);
            wait_end();
            chk("R5 K ticks", k_ticks - k0, RES_US);
            chk("R5 SE0 ticks", e_ticks - e0, EOP_US);
            chk("R6 view", port_view, hs ? 1 : 0);
            chk("R9 err", late_sof_err, rs ? 0 : 1);
            line_state = 2'b01; pcd_clr = 1'b1;
            @(negedge clk);
            pcd_clr = 1'b0;
            chk("R10 cleared", port_change, 0);
        end

        // R12: write of 1 while idle
        run_stop = 1'b1; port_hs = 1'b0;
        @(negedge clk);
        fpr_wr = 1'b1; fpr_wdata = 1'b1;
        @(negedge clk);
        fpr_wr = 1'b0;
        chk("R12 resume", resume_bit, 0);
        chk("R12 view", port_view, 0);

        // R11: J->K while idle, then SE0->K while suspended
        line_state = 2'b10;
        @(negedge clk);
        chk("R11 idle change", port_change, 0);
        chk("R11 idle view", port_view, 0);
        line_state = 2'b00; suspend_req = 1'b1;
        @(negedge clk);
        suspend_req = 1'b0; line_state = 2'b10;
        @(negedge clk);
        chk("R11 no wake view", port_view, 2);
        chk("R11 no wake change", port_change, 0);

        // R7: writes of 0
        line_state = 2'b01; fpr_wr = 1'b1; fpr_wdata = 1'b0;
        @(negedge clk);
        fpr_wr = 1'b0;
        chk("R7 suspended", port_view, 2);
        chk("R7 resume", resume_bit, 0);
        k0 = k_ticks;
        fpr_wr = 1'b1; fpr_wdata = 1'b1;
        @(negedge clk);
        fpr_wr = 1'b1; fpr_wdata = 1'b0;
        @(negedge clk);
        fpr_wr = 1'b0;
        repeat (2) @(negedge clk);
        chk("R7 still resuming", resume_bit, 1);
        wait_end();
        chk("R7 full K length", k_ticks - k0, RES_US);

        // R10: wakeup wins over clear in the same cycle
        do_suspend(1'b0);
        line_state = 2'b10; pcd_clr = 1'b1;
        @(negedge clk);
        pcd_clr = 1'b0;
        chk("R10 set wins", port_change, 1);
        pcd_clr = 1'b1;
        @(negedge clk);
        pcd_clr = 1'b0;
        chk("R10 clear", port_change, 0);
        wait_end();
        line_state = 2'b01;

        // R8: power loss mid-resume
        do_suspend(1'b1);
        fpr_wr = 1'b1; fpr_wdata = 1'b1;
        @(negedge clk);
        fpr_wr = 1'b0;
        repeat (4) @(negedge clk);
        port_power = 1'b0;
        #1;
        chk("R8 resume zero", resume_bit, 0);
        chk("R8 drive_k zero", drive_k, 0);
        suspend_req = 1'b1;
        @(negedge clk);
        chk("R8 view fs idle", port_view, 0);
        @(negedge clk);
        suspend_req = 1'b0;
        chk("R8 suspend ignored", port_view, 0);
        chk("R8 no drive", drive_k | drive_se0, 0);
        port_power = 1'b1;
        repeat (2) @(negedge clk);

        $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
        $finish;
    end
endmodule